// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit carries out the second-bank instructions of an 8-bit processor: rotates and shifts, a nibble exchange, single-bit test, single-bit clear and single-bit set. The caller presents the second-bank opcode byte, the operand value already fetched, and the current flag nibble, then raises `start_i` for one cycle. On the next clock edge the unit registers the new operand value, a write-back enable, the new flags, and the operand location named by the opcode.

The unit does not fetch operands and does not write them back. It reports which of the eight operand locations the opcode names. It also reports whether that location is the memory byte addressed by the pointer pair, so the surrounding pipeline can steer the write-back. Between start pulses the registered outputs keep their values.

Top module: `bitop_unit`

## Requirements
- R1: Opcode bits [7:6] choose the class: 0 rotate/shift, 1 bit test, 2 bit clear, 3 bit set. Bits [5:3] form the selector and bits [2:0] the operand index.
- R2: For class 0 the selector picks, for values 0 to 7: rotate-left-circular, rotate-right-circular, rotate-left-through-carry, rotate-right-through-carry, arithmetic shift left, arithmetic shift right keeping bit 7, nibble swap, logical shift right. A circular rotate puts the bit that leaves one end into the other end.
- R3: Every rotate and shift places the bit shifted out into carry. The through-carry rotates shift the incoming carry in. Both shift-lefts and the logical shift-right shift in a zero.
- R4: Nibble swap exchanges bits [7:4] with [3:0] and clears carry, whatever the incoming carry.
- R5: In class 0, zero is set exactly when the result is 0, subtract and half-carry are cleared, and write-back is high.
- R6: In bit test, zero is the inverse of operand bit [selector], subtract is 0, half-carry is 1, carry is unchanged, write-back is low, and the result equals the operand.
- R7: Bit clear and bit set change only bit [selector] of the operand, keep all four flags unchanged, and raise write-back.
- R8: `dest_o` repeats opcode bits [2:0]. `mem_o` is high exactly when that index is 6, the memory operand.
- R9: All outputs change on the clock edge that samples `start_i` high, and `valid_o` is high for exactly the following cycle. Without a start the data outputs hold.
- R10: After reset every output is 0.
- R11: The flag nibble on `flags_i` and `flags_o` is packed with zero in [3], subtract in [2], half-carry in [1] and carry in [0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to execute |
| opcode_i | input | 8 | Second-bank opcode byte |
| operand_i | input | 8 | Fetched operand value |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| result_o | output | 8 | Registered result value |
| flags_o | output | 4 | Registered new flags {Z,N,H,C} |
| wr_en_o | output | 1 | Result should be written back |
| dest_o | output | 3 | Operand location index |
| mem_o | output | 1 | Operand location is memory |
| valid_o | output | 1 | Outputs updated this cycle |

## Verification
The bench runs each of the eight rotate/shift selectors over operands whose end bits differ and under both carry values. A swapped selector order, or a circular rotate that feeds carry into the result, would give wrong results. Shifting 0x80 left must give a zero result with both zero and carry set, and shifting it right arithmetically must give 0xC0. A design that mixed up the shift kinds or derived zero before the shift would miss one of these cases. Swap runs with carry in set to catch a carry that is passed through instead of cleared. Bit test, clear and set run on every bit position with preset flags, to expose an inverted zero, a write-back during test, or flags overwritten during clear and set.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int SEL_W  = 3;
    localparam int FLAG_Z = 3;
    localparam int FLAG_N = 2;
    localparam int FLAG_H = 1;
    localparam int FLAG_C = 0;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'd0,
        CLS_TEST  = 2'd1,
        CLS_CLEAR = 2'd2,
        CLS_SET   = 2'd3
    } op_class_e;

    typedef enum logic [SEL_W-1:0] {
        SH_RLC  = 3'd0,
        SH_RRC  = 3'd1,
        SH_RL   = 3'd2,
        SH_RR   = 3'd3,
        SH_SLA  = 3'd4,
        SH_SRA  = 3'd5,
        SH_SWAP = 3'd6,
        SH_SRL  = 3'd7
    } shift_op_e;

    localparam logic [SEL_W-1:0] MEM_INDEX = 3'd6;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [7:0]       opcode_i,
    output op_class_e        cls_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [SEL_W-1:0] reg_o,
    output logic             mem_o
);
    always_comb begin
        cls_o = op_class_e'(opcode_i[7:6]);
        sel_o = opcode_i[5:3];
        reg_o = opcode_i[2:0];
        mem_o = (opcode_i[2:0] == MEM_INDEX);
    end
endmodule

// File: rtl/bitop_shifter.sv
module bitop_shifter
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              c_i,
    input  logic [SEL_W-1:0]  op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        res_o = a_i;
        c_o   = 1'b0;
        unique case (shift_op_e'(op_i))
            SH_RLC:  begin res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]}; c_o = a_i[DATA_W-1]; end
            SH_RRC:  begin res_o = {a_i[0], a_i[DATA_W-1:1]};        c_o = a_i[0];        end
            SH_RL:   begin res_o = {a_i[DATA_W-2:0], c_i};           c_o = a_i[DATA_W-1]; end
            SH_RR:   begin res_o = {c_i, a_i[DATA_W-1:1]};           c_o = a_i[0];        end
            SH_SLA:  begin res_o = {a_i[DATA_W-2:0], 1'b0};          c_o = a_i[DATA_W-1]; end
            SH_SRA:  begin res_o = {a_i[DATA_W-1], a_i[DATA_W-1:1]}; c_o = a_i[0];        end
            SH_SWAP: begin res_o = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]}; c_o = 1'b0;  end
            SH_SRL:  begin res_o = {1'b0, a_i[DATA_W-1:1]};          c_o = a_i[0];        end
            default: begin res_o = a_i; c_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bitop_bitmask.sv
module bitop_bitmask
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] mask_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask_o[i] = (sel_i == SEL_W'(i));
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o,
    output logic              wr_en_o,
    output logic [SEL_W-1:0]  dest_o,
    output logic              mem_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [3:0]        flags;
        logic              wr;
        logic [SEL_W-1:0]  dest;
        logic              mem;
        logic              valid;
    } out_t;

    op_class_e         cls;
    logic [SEL_W-1:0]  sel;
    logic [SEL_W-1:0]  reg_idx;
    logic              is_mem;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] mask;
    out_t              out_d, out_q;

    bitop_decode u_dec (
        .opcode_i (opcode_i),
        .cls_o    (cls),
        .sel_o    (sel),
        .reg_o    (reg_idx),
        .mem_o    (is_mem)
    );

    bitop_shifter #(.DATA_W(DATA_W)) u_sh (
        .a_i   (operand_i),
        .c_i   (flags_i[FLAG_C]),
        .op_i  (sel),
        .res_o (sh_res),
        .c_o   (sh_c)
    );

    bitop_bitmask #(.DATA_W(DATA_W)) u_mask (
        .sel_i  (sel),
        .mask_o (mask)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (start_i) begin
            out_d.valid = 1'b1;
            out_d.dest  = reg_idx;
            out_d.mem   = is_mem;
            out_d.flags = flags_i;
            unique case (cls)
                CLS_SHIFT: begin
                    out_d.data          = sh_res;
                    out_d.wr            = 1'b1;
                    out_d.flags[FLAG_Z] = (sh_res == '0);
                    out_d.flags[FLAG_N] = 1'b0;
                    out_d.flags[FLAG_H] = 1'b0;
                    out_d.flags[FLAG_C] = sh_c;
                end
                CLS_TEST: begin
                    out_d.data          = operand_i;
                    out_d.wr            = 1'b0;
                    out_d.flags[FLAG_Z] = ((operand_i & mask) == '0);
                    out_d.flags[FLAG_N] = 1'b0;
                    out_d.flags[FLAG_H] = 1'b1;
                end
                CLS_CLEAR: begin
                    out_d.data = operand_i & ~mask;
                    out_d.wr   = 1'b1;
                end
                CLS_SET: begin
                    out_d.data = operand_i | mask;
                    out_d.wr   = 1'b1;
                end
                default: out_d.wr = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o = out_q.data;
    assign flags_o  = out_q.flags;
    assign wr_en_o  = out_q.wr;
    assign dest_o   = out_q.dest;
    assign mem_o    = out_q.mem;
    assign valid_o  = out_q.valid;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [7:0]        opcode_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [3:0]        flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [3:0]        flags_o,
    input logic              wr_en_o,
    input logic [2:0]        dest_o,
    input logic              mem_o,
    input logic              valid_o
);
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o && $stable(result_o) && $stable(flags_o));
    assert_shift_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && opcode_i[7:6] == 2'd0) |=>
            wr_en_o && !flags_o[2] && !flags_o[1] && (flags_o[3] == (result_o == '0)));
    assert_swap_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && opcode_i[7:3] == 5'b00110) |=> !flags_o[0]);
    assert_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && opcode_i[7:6] == 2'd1) |=>
            !wr_en_o && flags_o[1] && !flags_o[2] && result_o == $past(operand_i)
            && flags_o[0] == $past(flags_i[0]));
    assert_modify_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && opcode_i[7]) |=> wr_en_o && flags_o == $past(flags_i)
            && $countones(result_o ^ $past(operand_i)) <= 1);
    assert_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> dest_o == $past(opcode_i[2:0]) && mem_o == ($past(opcode_i[2:0]) == 3'd6));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opcode_i = '0;
    logic [7:0] operand_i = '0;
    logic [3:0] flags_i = '0;
    logic [7:0] result_o;
    logic [3:0] flags_o;
    logic       wr_en_o;
    logic [2:0] dest_o;
    logic       mem_o;
    logic       valid_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bitop_unit dut (.*);

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // independent model: returns {result, wr, flags}
    function automatic logic [12:0] model(logic [7:0] op, logic [7:0] a, logic [3:0] f);
        logic [7:0] r;
        logic c, z, n, h, w;
        logic [2:0] y;
        y = op[5:3];
        r = a; c = f[0]; z = f[3]; n = f[2]; h = f[1]; w = 1'b1;
        if (op[7:6] == 2'd0) begin
            case (y)
                3'd0: begin r = (a << 1) | (a >> 7); c = a[7]; end
                3'd1: begin r = (a >> 1) | (a << 7); c = a[0]; end
                3'd2: begin r = (a << 1) | {7'd0, f[0]}; c = a[7]; end
                3'd3: begin r = (a >> 1) | {f[0], 7'd0}; c = a[0]; end
                3'd4: begin r = a << 1; c = a[7]; end
                3'd5: begin r = (a >> 1) | (a & 8'h80); c = a[0]; end
                3'd6: begin r = (a << 4) | (a >> 4); c = 1'b0; end
                default: begin r = a >> 1; c = a[0]; end
            endcase
            z = (r == 8'd0); n = 1'b0; h = 1'b0;
        end else if (op[7:6] == 2'd1) begin
            z = ((a >> y) & 8'd1) == 8'd0; n = 1'b0; h = 1'b1; w = 1'b0;
        end else if (op[7:6] == 2'd2) begin
            r = a & ~(8'd1 << y);
        end else begin
            r = a | (8'd1 << y);
        end
        return {r, w, z, n, h, c};
    endfunction

    task automatic run(logic [7:0] op, logic [7:0] a, logic [3:0] f, string req);
        logic [12:0] e;
        e = model(op, a, f);
        @(negedge clk);
        opcode_i = op; operand_i = a; flags_i = f; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        operand_i = ~a; flags_i = ~f;
        check({req, " R9 valid"}, valid_o, 1);
        check({req, " result"}, result_o, e[12:5]);
        check({req, " wr"}, wr_en_o, e[4]);
        check({req, " flags R11"}, flags_o, e[3:0]);
    endtask

    task automatic t_reset();
        check("R10 result", result_o, 0);
        check("R10 flags", flags_o, 0);
        check("R10 wr/valid/mem/dest", {wr_en_o, valid_o, mem_o, dest_o}, 0);
    endtask

    task automatic t_shifts();
        logic [7:0] vals [6] = '{8'h00, 8'h80, 8'h01, 8'hA5, 8'h3C, 8'hFF};
        for (int y = 0; y < 8; y++)
            for (int v = 0; v < 6; v++)
                for (int c = 0; c < 2; c++)
                    run({2'd0, 3'(y), 3'd7}, vals[v], {3'b101, 1'(c)}, "R2 R3 R5 shift");
    endtask

    task automatic t_corners();
        run(8'h27, 8'h80, 4'h0, "R3 SLA 0x80");
        check("R3 SLA zero+carry", flags_o, 4'b1001);
        run(8'h2F, 8'h80, 4'h0, "R2 SRA 0x80");
        check("R2 SRA sign", result_o, 8'hC0);
        run(8'h37, 8'hF0, 4'h1, "R4 swap");
        check("R4 swap nibble", result_o, 8'h0F);
        check("R4 swap carry cleared", flags_o[0], 0);
        run(8'h17, 8'h00, 4'h1, "R3 RL carry in");
        check("R3 RL carry in", result_o, 8'h01);
    endtask

    task automatic t_bitops();
        for (int y = 0; y < 8; y++) begin
            run({2'd1, 3'(y), 3'd0}, 8'h5A, 4'b0101, "R6 test");
            run({2'd1, 3'(y), 3'd0}, 8'hA5, 4'b1010, "R6 test");
            run({2'd2, 3'(y), 3'd1}, 8'hFF, 4'b1011, "R7 clear");
            run({2'd2, 3'(y), 3'd1}, 8'h00, 4'b0100, "R7 clear unset");
            run({2'd3, 3'(y), 3'd2}, 8'h00, 4'b1110, "R7 set");
            run({2'd3, 3'(y), 3'd2}, 8'hFF, 4'b0001, "R7 set already");
        end
        run(8'h7F, 8'h7F, 4'b0001, "R6 bit7");
        check("R6 bit7 zero", flags_o, 4'b1011);
    endtask

    task automatic t_decode();
        for (int z = 0; z < 8; z++) begin
            run({2'd3, 3'd4, 3'(z)}, 8'h00, 4'h0, "R1 R8 decode");
            check("R8 dest", dest_o, z);
            check("R8 mem", mem_o, (z == 6));
        end
    endtask

    task automatic t_hold();
        logic [7:0] r;
        logic [3:0] f;
        run(8'hC6, 8'h10, 4'h9, "R9 hold prep");
        r = result_o; f = flags_o;
        opcode_i = 8'h00; operand_i = 8'hFF;
        repeat (3) @(negedge clk);
        check("R9 hold valid low", valid_o, 0);
        check("R9 hold result", result_o, r);
        check("R9 hold flags", flags_o, f);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_shifts();
        t_corners();
        t_bitops();
        t_decode();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule